// File: doc/BRIEF.md
# Two-Team Match Scoreboard Controller

This block keeps the scores of two teams, yellow and red, during a match, and drives one indicator LED per team. A level input opens and closes the match. Opening a match clears both scores to zero. While the match is open, the block takes decoded score commands: each command names a team and a point value of 1, 2 or 3. The block adds the points to that team's two-digit decimal score and lights that team's LED.

Closing the match freezes both scores. The LED of the team with the higher score then blinks with a 50 % duty cycle, and the other LED stays dark. The half-period is a parameter. Its default of 6,250,000 cycles gives 4 Hz from a 50 MHz clock.

Both scores leave the block as BCD digit pairs for an external display driver. Yellow's pair goes to the two leftmost display positions and red's pair to the two rightmost. Keypad scanning and display multiplexing happen outside this block.

Top module: `scoreboard_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both scores become 00 and both LEDs go dark. The blink divider is also cleared.
- R2: If `match_on` is high at an edge and the match is not already open, the match opens at that edge. Both scores read 00 and both LEDs are dark after that edge.
- R3: While the match is open, an edge with `match_on` and `cmd_valid` high adds `cmd_points` (1, 2 or 3) to one team. `cmd_team` selects the team: 0 is yellow, 1 is red. The new score appears after that same edge. A `cmd_points` value of 0 leaves both scores unchanged.
- R4: Each score is stored as two BCD digits, each in the range 0 to 9. When the units digit passes 9, the excess wraps around and one is carried into the tens digit.
- R5: A score that would pass 99 is held at 99.
- R6: While the match is open, an accepted command lights the scoring team's LED and turns the other LED off. This state holds until the next accepted command.
- R7: A score command is ignored in the following cases: before the first match, after a match has closed, in the cycle in which `match_on` falls, and in the cycle in which the match opens.
- R8: The match closes at the first edge where `match_on` is low. From that edge, the leader's LED is lit for HALF_PERIOD cycles, then dark for HALF_PERIOD cycles, and this pattern repeats. The other LED stays dark.
- R9: If the scores are equal when the match closes, both LEDs stay dark.
- R10: After the match closes, both scores keep their final values until the next match opens or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| match_on | input | 1 | Match switch level: high opens the match, low closes it |
| cmd_valid | input | 1 | A score command is present this cycle |
| cmd_team | input | 1 | Team of the command: 0 yellow, 1 red |
| cmd_points | input | 2 | Points to add (1 to 3; 0 has no effect) |
| yel_tens | output | 4 | Yellow score tens digit (display position 1) |
| yel_units | output | 4 | Yellow score units digit (display position 2) |
| red_tens | output | 4 | Red score tens digit (display position 7) |
| red_units | output | 4 | Red score units digit (display position 8) |
| led_yellow | output | 1 | Yellow team LED |
| led_red | output | 1 | Red team LED |

## Verification
A score command can reach the block in the same cycle as either edge of the match switch. The bench provokes both cases by changing `match_on` and raising `cmd_valid` at the same falling clock edge.

When the match opens, the clear must win: the bench expects 00 on both teams and both LEDs dark. When the match closes, the command must be dropped: the bench expects the scores from before the command, and then a blink pattern chosen from those unchanged scores. A command on the last open cycle that slipped through would flip the leader and the bench would see the wrong LED blink.

// File: rtl/scoreboard_pkg.sv
package scoreboard_pkg;

    localparam int DIGIT_W = 4;
    localparam int PTS_W   = 2;
    localparam int TEAMS   = 2;

    // team index as carried on cmd_team
    localparam logic TEAM_YEL = 1'b0;
    localparam logic TEAM_RED = 1'b1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
    } bcd2_t;

endpackage

// File: rtl/bcd_sat_add.sv
module bcd_sat_add
    import scoreboard_pkg::*;
(
    input  bcd2_t            cur,
    input  logic [PTS_W-1:0] pts,
    output bcd2_t            sum
);
    localparam logic [DIGIT_W:0] NINE = (DIGIT_W+1)'(9);
    localparam logic [DIGIT_W:0] TEN  = (DIGIT_W+1)'(10);

    logic [DIGIT_W:0] units_raw;
    logic [DIGIT_W:0] tens_raw;
    logic             carry;

    always_comb begin
        units_raw = {1'b0, cur.units} + (DIGIT_W+1)'(pts);
        carry     = (units_raw > NINE);
        if (carry) begin
            units_raw = units_raw - TEN;
        end
        tens_raw = {1'b0, cur.tens} + (DIGIT_W+1)'(carry);
        if (tens_raw > NINE) begin
            sum.tens  = DIGIT_W'(9);
            sum.units = DIGIT_W'(9);
        end else begin
            sum.tens  = tens_raw[DIGIT_W-1:0];
            sum.units = units_raw[DIGIT_W-1:0];
        end
    end
endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
    parameter int HALF_PERIOD = 6_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic en,
    output logic lit
);
    localparam int CNT_W = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lit;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (restart) begin
            div_d.cnt = '0;
            div_d.lit = 1'b1;
        end else if (en) begin
            if (div_q.cnt == LAST) begin
                div_d.cnt = '0;
                div_d.lit = ~div_q.lit;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign lit = div_q.lit;
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import scoreboard_pkg::*;
#(
    parameter int HALF_PERIOD = 6_250_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               match_on,
    input  logic               cmd_valid,
    input  logic               cmd_team,
    input  logic [PTS_W-1:0]   cmd_points,
    output logic [DIGIT_W-1:0] yel_tens,
    output logic [DIGIT_W-1:0] yel_units,
    output logic [DIGIT_W-1:0] red_tens,
    output logic [DIGIT_W-1:0] red_units,
    output logic               led_yellow,
    output logic               led_red
);
    typedef struct packed {
        phase_e                 phase;
        bcd2_t [TEAMS-1:0]      score;
        logic  [TEAMS-1:0]      led;
    } st_t;

    st_t st_d, st_q;

    bcd2_t [TEAMS-1:0] sum;
    logic              open_now;
    logic              close_now;
    logic              accept;
    logic              blink_lit;
    logic              yel_leads;
    logic              red_leads;

    // one saturating BCD adder per team
    for (genvar g = 0; g < TEAMS; g++) begin : g_team
        bcd_sat_add u_add (
            .cur (st_q.score[g]),
            .pts (cmd_points),
            .sum (sum[g])
        );
    end

    blink_divider #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_blink (
        .clk     (clk),
        .rst     (rst),
        .restart (close_now),
        .en      (st_q.phase == PH_DONE),
        .lit     (blink_lit)
    );

    always_comb begin
        st_d      = st_q;
        open_now  = match_on && (st_q.phase != PH_RUN);
        close_now = !match_on && (st_q.phase == PH_RUN);
        accept    = cmd_valid && match_on && (st_q.phase == PH_RUN)
                    && (cmd_points != '0);
        if (open_now) begin
            st_d.phase = PH_RUN;
            st_d.score = '0;
            st_d.led   = '0;
        end else if (close_now) begin
            st_d.phase = PH_DONE;
        end else if (accept) begin
            st_d.score[cmd_team] = sum[cmd_team];
            st_d.led             = '0;
            st_d.led[cmd_team]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, score: '0, led: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // packed BCD pairs compare in numeric order since each digit is 0..9
    assign yel_leads = st_q.score[TEAM_YEL] > st_q.score[TEAM_RED];
    assign red_leads = st_q.score[TEAM_RED] > st_q.score[TEAM_YEL];

    always_comb begin
        if (st_q.phase == PH_DONE) begin
            led_yellow = blink_lit && yel_leads;
            led_red    = blink_lit && red_leads;
        end else begin
            led_yellow = st_q.led[TEAM_YEL];
            led_red    = st_q.led[TEAM_RED];
        end
    end

    assign yel_tens  = st_q.score[TEAM_YEL].tens;
    assign yel_units = st_q.score[TEAM_YEL].units;
    assign red_tens  = st_q.score[TEAM_RED].tens;
    assign red_units = st_q.score[TEAM_RED].units;
endmodule

// File: rtl/scoreboard_ctrl_chk.sv
module scoreboard_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       match_on,
    input logic [3:0] yel_tens,
    input logic [3:0] yel_units,
    input logic [3:0] red_tens,
    input logic [3:0] red_units,
    input logic       led_yellow,
    input logic       led_red
);
    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (rst)
        (yel_tens <= 4'd9) && (yel_units <= 4'd9)
        && (red_tens <= 4'd9) && (red_units <= 4'd9)); // R4

    AST_ONE_LED_AT_MOST: assert property (@(posedge clk) disable iff (rst)
        !(led_yellow && led_red)); // R6

    AST_SWITCH_LOW_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (!match_on) |=> ($stable(yel_tens) && $stable(yel_units)
                         && $stable(red_tens) && $stable(red_units))); // R7

    AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(match_on) |=> ({yel_tens, yel_units, red_tens, red_units} == 16'h0
                             && !led_yellow && !led_red)); // R2

    AST_YEL_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (match_on && $past(match_on) && !$past(rst)
         && yel_tens == 4'd9 && yel_units == 4'd9)
        |=> (yel_tens == 4'd9 && yel_units == 4'd9)); // R5

    AST_RED_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (match_on && $past(match_on) && !$past(rst)
         && red_tens == 4'd9 && red_units == 4'd9)
        |=> (red_tens == 4'd9 && red_units == 4'd9)); // R5
endmodule

bind scoreboard_ctrl scoreboard_ctrl_chk u_chk (.*);

// File: tb/scoreboard_ctrl_test.sv
`timescale 1ns/1ps
module scoreboard_ctrl_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       match_on = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_team = 1'b0;
    logic [1:0] cmd_points = 2'd0;
    logic [3:0] yel_tens, yel_units, red_tens, red_units;
    logic       led_yellow, led_red;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_y  = 0;
    int exp_r  = 0;

    always #2.5 clk = ~clk;

    scoreboard_ctrl #(.HALF_PERIOD(HALF)) uut (
        .clk(clk), .rst(rst), .match_on(match_on), .cmd_valid(cmd_valid),
        .cmd_team(cmd_team), .cmd_points(cmd_points),
        .yel_tens(yel_tens), .yel_units(yel_units),
        .red_tens(red_tens), .red_units(red_units),
        .led_yellow(led_yellow), .led_red(led_red)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int score_y();
        return int'(yel_tens) * 10 + int'(yel_units);
    endfunction
    function automatic int score_r();
        return int'(red_tens) * 10 + int'(red_units);
    endfunction

    task automatic chk_scores(string req);
        chk({req, " yellow score"}, score_y(), exp_y);
        chk({req, " red score"}, score_r(), exp_r);
    endtask

    // one command cycle; outputs sampled one cycle later at the negedge
    task automatic send(logic team, int pts, logic counts);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_team   = team;
        cmd_points = 2'(pts);
        @(negedge clk);
        cmd_valid  = 1'b0;
        cmd_points = 2'd0;
        if (counts) begin
            if (team == 1'b0) exp_y = (exp_y + pts > 99) ? 99 : exp_y + pts;
            else              exp_r = (exp_r + pts > 99) ? 99 : exp_r + pts;
        end
    endtask

    task automatic open_match();
        @(negedge clk);
        match_on = 1'b1;
        @(negedge clk);
        exp_y = 0;
        exp_r = 0;
    endtask

    // closes and checks two full blink periods sample by sample
    task automatic close_and_blink(string req, int want_y, int want_r);
        int bad_y = 0;
        int bad_r = 0;
        @(negedge clk);
        match_on = 1'b0;
        for (int i = 0; i < 4 * HALF; i++) begin
            logic on;
            @(negedge clk);
            on = ((i / HALF) % 2) == 0;
            if (led_yellow !== (on && want_y != 0)) bad_y++;
            if (led_red !== (on && want_r != 0)) bad_r++;
        end
        chk({req, " yellow blink errors"}, bad_y, 0);
        chk({req, " red blink errors"}, bad_r, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_scores("R1 reset");
        chk("R1 reset led_yellow", int'(led_yellow), 0);
        chk("R1 reset led_red", int'(led_red), 0);
        rst = 1'b0;
        send(1'b0, 3, 1'b0);
        chk_scores("R7 idle command");
    endtask

    task automatic t_scoring();
        open_match();
        chk_scores("R2 open");
        send(1'b0, 1, 1'b1);
        chk_scores("R3 yellow +1");
        chk("R6 yellow lit", int'(led_yellow), 1);
        chk("R6 red dark", int'(led_red), 0);
        send(1'b1, 2, 1'b1);
        chk_scores("R3 red +2");
        chk("R6 red lit", int'(led_red), 1);
        chk("R6 yellow dark", int'(led_yellow), 0);
        send(1'b0, 0, 1'b0);
        chk_scores("R3 zero points");
        chk("R6 led kept on zero points", int'(led_red), 1);
        send(1'b0, 3, 1'b1);
        send(1'b0, 3, 1'b1);
        send(1'b0, 3, 1'b1);
        chk_scores("R4 carry to tens");
        chk("R4 yellow units", int'(yel_units), 0);
        chk("R4 yellow tens", int'(yel_tens), 1);
        close_and_blink("R8 yellow leads", 1, 0);
        chk_scores("R10 held after close");
        send(1'b1, 3, 1'b0);
        chk_scores("R7 after close");
    endtask

    task automatic t_saturate();
        open_match();
        chk("R2 reopen led_yellow", int'(led_yellow), 0);
        for (int i = 0; i < 34; i++) send(1'b0, 3, 1'b1);
        chk_scores("R5 yellow saturates");
        chk("R5 yellow at 99", score_y(), 99);
        for (int i = 0; i < 32; i++) send(1'b1, 3, 1'b1);
        send(1'b1, 2, 1'b1);
        send(1'b1, 3, 1'b1);
        chk("R5 red 98 plus 3", score_r(), 99);
        close_and_blink("R9 tie at 99", 0, 0);
    endtask

    task automatic t_collisions();
        // command in the opening cycle is dropped
        @(negedge clk);
        match_on   = 1'b1;
        cmd_valid  = 1'b1;
        cmd_team   = 1'b0;
        cmd_points = 2'd3;
        @(negedge clk);
        cmd_valid  = 1'b0;
        exp_y = 0;
        exp_r = 0;
        chk_scores("R7 open collision");
        send(1'b1, 1, 1'b1);
        // red leads 1:0; yellow +2 on the closing cycle must be dropped
        @(negedge clk);
        match_on   = 1'b0;
        cmd_valid  = 1'b1;
        cmd_team   = 1'b0;
        cmd_points = 2'd2;
        @(negedge clk);
        cmd_valid  = 1'b0;
        chk_scores("R7 close collision");
        chk("R8 red lit at close", int'(led_red), 1);
        chk("R8 yellow dark at close", int'(led_yellow), 0);
        match_on = 1'b1;
        @(negedge clk);
        match_on = 1'b1;
        exp_y = 0;
        exp_r = 0;
        send(1'b1, 2, 1'b1);
        close_and_blink("R8 red leads", 0, 1);
        // reset in the done phase
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_y = 0;
        exp_r = 0;
        chk_scores("R1 reset after match");
        chk("R1 red led after reset", int'(led_red), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_scoring();
        t_saturate();
        t_collisions();
        summary();
        $finish;
    end
endmodule